// File: doc/BRIEF.md
# PS/2 Keyboard/Mouse Register Interface

This block is the processor-facing register set of a PS/2 keyboard or mouse port. A simple single-access register bus reaches a 4 KB window holding control, status, data, clock-divider and interrupt-status registers, with a read-only identification area in the last 32 bytes. Bytes arriving from the device side are offered on a byte port with an availability level. A read of the data register takes the offered byte, latches it as the last byte and pulses a pop strobe back to the device side. Bytes the processor writes to the data register go out on a transmit port as a one-cycle strobe.

Transmit is modelled as always empty, so the transmit interrupt enable alone raises the interrupt. Receive parity is derived from the last byte read, not from the line. The block drives one level interrupt. The serial clock/data wire protocol and the keyboard or mouse internals live outside it.

Top module: `ps2if_top`

## Requirements
- R1: After reset the control, clock-divider and last-byte registers hold zero, so with no byte available the interrupt is low and status reads 0x40.
- R2: Registers sit at word index (byte offset >> 2): 0 control, 1 status, 2 data, 3 clock divider, 4 interrupt status. Control and clock divider store the full 32-bit write and read it back.
- R3: Status reads bit 6 = 1 (transmit empty), bit 4 = byte available, bit 2 = 1 when the last-byte register holds an odd number of ones, all other bits 0.
- R4: A data read while a byte is available pulses rx_pop_o high in the request cycle, returns that byte and stores it as the last byte.
- R5: A data read with no byte available raises no pop and returns the last byte unchanged.
- R6: irq_o is high when control bit 3 is set, or when control bit 4 is set and a byte is available. It follows a control write from the next cycle.
- R7: Interrupt status reads bit 0 = byte available and bit 1 = 1, other bits 0.
- R8: A data write puts wdata[7:0] on tx_byte_o with tx_valid_o high for exactly the one cycle after the write.
- R9: Reads at byte offsets 0xFE0 to 0xFFF return one identification byte per word, indexed by (offset − 0xFE0) >> 2, in the order 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Writes to status, interrupt status or unmapped offsets change no register and raise no transmit strobe. Reads of unmapped offsets below 0xFE0 return 0.
- R11: A read request is answered the cycle after: bus_rvalid_o is high for one cycle with bus_rdata_o valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset in the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read response strobe |
| rx_byte_i | input | 8 | Byte offered by the device side |
| rx_avail_i | input | 1 | Device side has a byte |
| rx_pop_o | output | 1 | Byte consumed this cycle |
| tx_byte_o | output | 8 | Byte to send to the device |
| tx_valid_o | output | 1 | tx_byte_o valid strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The pop of a received byte and a change of the device side's availability can fall in the same cycle. The bench makes a byte available in the very cycle a data read is issued, and expects the pop strobe, that byte as read data, and a status and interrupt that reflect the new byte. Random runs mix device-side pushes with reads and control writes, and a reference model of queue, last byte and control judges each response.

// File: rtl/ps2if_pkg.sv
package ps2if_pkg;
  typedef enum logic [2:0] {
    RI_CTRL  = 3'd0,
    RI_STAT  = 3'd1,
    RI_DATA  = 3'd2,
    RI_CDIV  = 3'd3,
    RI_ISTAT = 3'd4,
    RI_ID    = 3'd5,
    RI_NONE  = 3'd7
  } reg_idx_e;

  localparam int ST_TXE_BIT  = 6;
  localparam int ST_RXF_BIT  = 4;
  localparam int ST_PAR_BIT  = 2;
  localparam int IS_ONE_BIT  = 1;
  localparam int IS_RX_BIT   = 0;
  localparam int CR_RXIE_BIT = 4;
  localparam int CR_TXIE_BIT = 3;
  localparam int ID_BYTES    = 32;

  function automatic logic [7:0] id_byte(input logic [2:0] n);
    case (n)
      3'd0:    return 8'h50;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ps2if_decode.sv
module ps2if_decode
  import ps2if_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_idx_e          idx_o,
  output logic [2:0]        id_n_o,
  output logic              ctrl_we_o,
  output logic              cdiv_we_o,
  output logic              tx_we_o,
  output logic              data_rd_o
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'((1 << ADDR_W) - ID_BYTES);

  logic [WIDX_W-1:0] widx;
  logic              unused_lsb;

  assign widx       = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign id_n_o     = addr_i[4:2];

  always_comb begin
    if (addr_i >= ID_BASE) begin
      idx_o = RI_ID;
    end else begin
      case (widx)
        WIDX_W'(0): idx_o = RI_CTRL;
        WIDX_W'(1): idx_o = RI_STAT;
        WIDX_W'(2): idx_o = RI_DATA;
        WIDX_W'(3): idx_o = RI_CDIV;
        WIDX_W'(4): idx_o = RI_ISTAT;
        default:    idx_o = RI_NONE;
      endcase
    end
  end

  assign ctrl_we_o = sel_i &  we_i & (idx_o == RI_CTRL);
  assign cdiv_we_o = sel_i &  we_i & (idx_o == RI_CDIV);
  assign tx_we_o   = sel_i &  we_i & (idx_o == RI_DATA);
  assign data_rd_o = sel_i & ~we_i & (idx_o == RI_DATA);
endmodule

// File: rtl/ps2if_rx.sv
module ps2if_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_rd_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_avail_i,
  output logic              rx_pop_o,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              parity_o
);
  logic [BYTE_W-1:0] last_q;

  assign rx_pop_o  = data_rd_i & rx_avail_i;
  assign rd_byte_o = rx_pop_o ? rx_byte_i : last_q;
  assign parity_o  = ^last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= '0;
    else if (rx_pop_o) last_q <= rx_byte_i;
  end

  p_pop_needs_avail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> rx_avail_i);
  p_pop_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |=> last_q == $past(rx_byte_i));
  p_last_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_pop_o |=> $stable(last_q));
endmodule

// File: rtl/ps2if_ctrl.sv
module ps2if_ctrl
  import ps2if_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              cdiv_we_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rx_avail_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cdiv_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_valid_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q, cdiv_q;
  logic [BYTE_W-1:0] tx_q;
  logic              txv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cdiv_q <= '0;
      tx_q   <= '0;
      txv_q  <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= wdata_i;
      if (cdiv_we_i) cdiv_q <= wdata_i;
      if (tx_we_i)   tx_q   <= wdata_i[BYTE_W-1:0];
      txv_q <= tx_we_i;
    end
  end

  // transmit side never fills, so its enable alone raises the line
  assign irq_o      = ctrl_q[CR_TXIE_BIT] | (ctrl_q[CR_RXIE_BIT] & rx_avail_i);
  assign ctrl_o     = ctrl_q;
  assign cdiv_o     = cdiv_q;
  assign tx_byte_o  = tx_q;
  assign tx_valid_o = txv_q;

  p_tx_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_i |=> tx_valid_o && tx_byte_o == $past(wdata_i[BYTE_W-1:0]));
  p_tx_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_we_i |=> !tx_valid_o);
  p_ctrl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o));
  p_cdiv_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cdiv_we_i |=> $stable(cdiv_o));
  p_irq_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[CR_TXIE_BIT] && !rx_avail_i) |-> !irq_o);
endmodule

// File: rtl/ps2if_top.sv
module ps2if_top
  import ps2if_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_avail_i,
  output logic              rx_pop_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_valid_o,
  output logic              irq_o
);
  reg_idx_e          idx;
  logic [2:0]        id_n;
  logic              ctrl_we, cdiv_we, tx_we, data_rd, parity;
  logic [BYTE_W-1:0] rd_byte;
  logic [DATA_W-1:0] ctrl, cdiv, status, istat, rd_mux, rdata_q;
  logic              rvalid_q;

  ps2if_decode #(.ADDR_W(ADDR_W)) i_decode (
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .idx_o(idx), .id_n_o(id_n), .ctrl_we_o(ctrl_we), .cdiv_we_o(cdiv_we),
    .tx_we_o(tx_we), .data_rd_o(data_rd)
  );

  ps2if_rx #(.BYTE_W(BYTE_W)) i_rx (
    .clk_i, .rst_ni, .data_rd_i(data_rd), .rx_byte_i, .rx_avail_i,
    .rx_pop_o, .rd_byte_o(rd_byte), .parity_o(parity)
  );

  ps2if_ctrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_ctrl (
    .clk_i, .rst_ni, .ctrl_we_i(ctrl_we), .cdiv_we_i(cdiv_we), .tx_we_i(tx_we),
    .wdata_i(bus_wdata_i), .rx_avail_i, .ctrl_o(ctrl), .cdiv_o(cdiv),
    .tx_byte_o, .tx_valid_o, .irq_o
  );

  always_comb begin
    status = '0;
    status[ST_TXE_BIT] = 1'b1;
    status[ST_RXF_BIT] = rx_avail_i;
    status[ST_PAR_BIT] = parity;
    istat = '0;
    istat[IS_ONE_BIT] = 1'b1;
    istat[IS_RX_BIT]  = rx_avail_i;
  end

  always_comb begin
    case (idx)
      RI_CTRL:  rd_mux = ctrl;
      RI_STAT:  rd_mux = status;
      RI_DATA:  rd_mux = DATA_W'(rd_byte);
      RI_CDIV:  rd_mux = cdiv;
      RI_ISTAT: rd_mux = istat;
      RI_ID:    rd_mux = DATA_W'(id_byte(id_n));
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_sel_i & ~bus_we_i;
      if (bus_sel_i && !bus_we_i) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  p_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i) |=> bus_rvalid_o);
  p_rvalid_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_sel_i && !bus_we_i) |=> !bus_rvalid_o);
  p_pop_is_data_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (bus_sel_i && !bus_we_i && idx == RI_DATA));
endmodule

// File: tb/test_ps2if_top.sv
module test_ps2if_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, pop, txv, irq;
  logic [7:0]  txb;
  logic [7:0]  mem [0:255];
  logic [7:0]  head = '0, tail = '0;
  logic        avail;
  logic [7:0]  rxb;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_ctrl = '0, exp_cdiv = '0;
  logic [7:0]  exp_last = '0;

  always #4 clk = ~clk;

  assign avail = (head != tail);
  assign rxb   = mem[head];

  always @(posedge clk) if (pop) head <= head + 8'd1;

  ps2if_top i_ps2if_top (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .rx_byte_i(rxb), .rx_avail_i(avail),
    .rx_pop_o(pop), .tx_byte_o(txb), .tx_valid_o(txv), .irq_o(irq)
  );

  function automatic logic [31:0] f_status(logic [7:0] last, logic av);
    return 32'h40 | (32'(av) << 4) | (32'(^last) << 2);
  endfunction
  function automatic logic f_irq(logic [31:0] c, logic av);
    return c[3] | (c[4] & av);
  endfunction
  function automatic logic [7:0] f_id(int k);
    logic [7:0] t [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    mem[tail] = b;
    tail = tail + 8'd1;
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  // optional push in the request cycle itself
  task automatic bus_read(logic [11:0] a, bit do_push, logic [7:0] pb,
                          output logic [31:0] d, output logic p);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    if (do_push) push(pb);
    #1 p = pop;
    @(negedge clk);
    d = rdata;
    chk("R11 rvalid", 32'(rvalid), 32'd1);
    sel = 1'b0;
  endtask

  task automatic read_data_checked(bit do_push, logic [7:0] pb);
    logic [31:0] d; logic p; logic [31:0] e; logic av;
    av = avail | do_push;
    e  = av ? 32'(do_push && !avail ? pb : mem[head]) : 32'(exp_last);
    bus_read(12'h008, do_push, pb, d, p);
    if (av) begin
      chk("R4 data", d, e); chk("R4 pop", 32'(p), 32'd1); exp_last = e[7:0];
    end else begin
      chk("R5 data", d, e); chk("R5 no pop", 32'(p), 32'd0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d; logic p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 chk("R1 irq", 32'(irq), 32'd0);
    bus_read(12'h000, 0, 0, d, p); chk("R1 ctrl", d, 32'd0);
    bus_read(12'h00C, 0, 0, d, p); chk("R1 cdiv", d, 32'd0);
    bus_read(12'h004, 0, 0, d, p); chk("R1 status", d, 32'h40);
    bus_read(12'h010, 0, 0, d, p); chk("R7 istat idle", d, 32'h2);
    read_data_checked(0, 0);

    // R6 receive enable
    bus_write(12'h000, 32'h10); exp_ctrl = 32'h10;
    #1 chk("R6 irq rxie idle", 32'(irq), 32'd0);
    push(8'h07);
    #1 chk("R6 irq rxie pending", 32'(irq), 32'd1);
    bus_read(12'h010, 0, 0, d, p); chk("R7 istat pending", d, 32'h3);
    bus_read(12'h004, 0, 0, d, p); chk("R3 status pending", d, 32'h50);
    read_data_checked(0, 0);
    bus_read(12'h004, 0, 0, d, p); chk("R3 status parity", d, 32'h44);
    read_data_checked(0, 0);

    // same-cycle arrival and pop
    read_data_checked(1, 8'h3C);
    bus_read(12'h004, 0, 0, d, p); chk("R3 status even", d, 32'h40);
    #1 chk("R6 irq after pop", 32'(irq), 32'd0);

    // R6 transmit enable alone
    bus_write(12'h000, 32'h08); exp_ctrl = 32'h08;
    #1 chk("R6 irq txie", 32'(irq), 32'd1);
    bus_write(12'h000, 32'hFFFF_FFE7); exp_ctrl = 32'hFFFF_FFE7;
    bus_read(12'h000, 0, 0, d, p); chk("R2 ctrl readback", d, exp_ctrl);
    #1 chk("R6 irq off", 32'(irq), 32'd0);
    bus_write(12'h00C, 32'hDEAD_BEEF); exp_cdiv = 32'hDEAD_BEEF;
    bus_read(12'h00C, 0, 0, d, p); chk("R2 cdiv readback", d, exp_cdiv);

    // R8 transmit
    bus_write(12'h008, 32'h0000_01A5);
    chk("R8 tx valid", 32'(txv), 32'd1); chk("R8 tx byte", 32'(txb), 32'hA5);
    @(negedge clk); chk("R8 tx single", 32'(txv), 32'd0);

    // R9 id area
    for (int k = 0; k < 8; k++) begin
      bus_read(12'hFE0 + 12'(4 * k), 0, 0, d, p);
      chk("R9 id", d, 32'(f_id(k)));
    end

    // R10 ignored writes
    bus_write(12'h004, 32'hFFFF_FFFF); chk("R10 no tx stat", 32'(txv), 32'd0);
    bus_write(12'h010, 32'hFFFF_FFFF);
    bus_write(12'h014, 32'h1234_5678);
    bus_write(12'h800, 32'h1234_5678); chk("R10 no tx unmapped", 32'(txv), 32'd0);
    bus_read(12'h000, 0, 0, d, p); chk("R10 ctrl kept", d, exp_ctrl);
    bus_read(12'h00C, 0, 0, d, p); chk("R10 cdiv kept", d, exp_cdiv);
    bus_read(12'h014, 0, 0, d, p); chk("R10 unmapped read", d, 32'd0);
    bus_read(12'hFDC, 0, 0, d, p); chk("R10 below id", d, 32'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 6));
      case (op)
        0: if (8'(tail - head) < 8'd200) push(8'($urandom));
        1: read_data_checked(($urandom & 3) == 0, 8'($urandom));
        2: begin bus_read(12'h004, 0, 0, d, p); chk("R3 status rand", d, f_status(exp_last, avail)); end
        3: begin exp_ctrl = $urandom; bus_write(12'h000, exp_ctrl); end
        4: begin bus_read(12'h010, 0, 0, d, p); chk("R7 istat rand", d, 32'h2 | 32'(avail)); end
        5: begin
             logic [31:0] w; w = $urandom;
             bus_write(12'h008, w);
             chk("R8 tx rand", {23'd0, txv, txb}, {23'd1, w[7:0]});
           end
        default: begin exp_cdiv = $urandom; bus_write(12'h00C, exp_cdiv);
                   bus_read(12'h00C, 0, 0, d, p); chk("R2 cdiv rand", d, exp_cdiv); end
      endcase
      #1 chk("R6 irq rand", 32'(irq), 32'(f_irq(exp_ctrl, avail)));
    end
    finish_run();
  end
endmodule